// File: doc/BRIEF.md
# Multiplier-Free Quadrature Upconversion Interpolator

This block is the last interpolation stage of a digital transmit chain. It receives one in-phase carrier sample X and one quadrature carrier sample Y per slow period (a quarter of the output rate). It raises the sample rate by four with a polyphase lowpass filter split into four subfilters. It then shifts the filtered band to 0, +fs/4, -fs/4 or fs/2 and emits one 12-bit sample per fast clock for a DAC.

The shift needs no mixer. At these four output frequencies every carrier term is 0, +1 or -1, so the modulation reduces to three things:
- choosing which carrier feeds which subfilter,
- flipping the sign of some subfilter results,
- reading the four results out in a fixed order.

A free-running two-bit phase counter sets the slow period. Samples and the mode and direction selects are taken only at phase 0.

Top module: `qup_interp`

## Requirements
- R1: After reset the phase counter is 0 and `dac_out` is 0. The counter advances by one each clock and wraps from 3 to 0. The first rising edge after reset is released is a phase-0 edge.
- R2: A sample is accepted at a phase-0 edge. Subfilter results 0, 1, 2 and 3 of that sample appear on `dac_out` after the 1st, 2nd, 3rd and 4th following rising edges.
- R3: The four subfilters have 8, 7, 7 and 7 fixed taps. The taps of each subfilter sum to 1024 (unity gain in Q10). After 8 equal samples, every subfilter output equals the input scaled to 12 bits.
- R4: Lowpass mode (`mode` 2'b00, and also 2'b11) feeds X to all subfilters and negates nothing. A steady X gives four equal outputs, and Y has no effect.
- R5: Bandpass mode (`mode` 2'b01) with `dir_neg` 0 (+fs/4) gives the sequence X, Y, -X, -Y.
- R6: Bandpass mode with `dir_neg` 1 (-fs/4) gives the sequence X, -Y, -X, Y.
- R7: Highpass mode (`mode` 2'b10) gives X, -X, X, -X. Y and `dir_neg` have no effect.
- R8: Scaling from 16 to 12 bits is floor((v+8)/16), saturated to [-2048, 2047]. So +8 gives 1, +7 gives 0, -8 gives 0 and -9 gives -1.
- R9: Negation saturates: -(-2048) gives 2047.
- R10: `in_valid` at phases 1 to 3 is ignored. A phase-0 edge without `in_valid` shifts zero into the filter.
- R11: `mode` and `dir_neg` are sampled only at phase-0 edges. Changing them between those edges has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast (output-rate) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Slow-rate sample strobe, used at phase 0 only |
| x_in | input | 16 | In-phase carrier sample, two's complement |
| y_in | input | 16 | Quadrature carrier sample, two's complement |
| mode | input | 2 | 00/11 lowpass, 01 bandpass, 10 highpass |
| dir_neg | input | 1 | Bandpass direction: 0 = +fs/4, 1 = -fs/4 |
| dac_out | output | 12 | Output sample, one per clock |

## Verification
The bench checks both bandpass directions. A design that negated the wrong Y branch would land on the mirror frequency, and the Y terms would swap sign in the sequence.

It drives the most negative input through highpass mode. A negator that wraps instead of saturating would emit -2048 where 2047 is expected.

It checks the rounding points on both sides of zero. It also checks that a strobe, or a change of mode or direction, arriving mid-period does not corrupt the filter history or the branch signs. Finally, it checks that a missing strobe pushes zero rather than repeating the last sample.

// File: rtl/qup_pkg.sv
package qup_pkg;

    typedef enum logic [1:0] {
        MODE_LOW  = 2'b00,
        MODE_BAND = 2'b01,
        MODE_HIGH = 2'b10,
        MODE_LOWB = 2'b11
    } qmode_e;

    // number of taps held by subfilter br
    function automatic int branch_taps(input int br);
        return (br == 0) ? 8 : 7;
    endfunction

    // fixed Q10 tap values; each subfilter sums to 1024
    function automatic int tap_coef(input int br, input int k);
        int c;
        c = 0;
        case (br)
            0: case (k)
                   0: c = -8;   1: c = 24;   2: c = -64;  3: c = 560;
                   4: c = 560;  5: c = -64;  6: c = 24;   7: c = -8;
                   default: c = 0;
               endcase
            1: case (k)
                   0: c = 10;   1: c = -50;  2: c = 170;  3: c = 940;
                   4: c = -60;  5: c = 16;   6: c = -2;
                   default: c = 0;
               endcase
            2: case (k)
                   0: c = -4;   1: c = -36;  2: c = 300;  3: c = 808;
                   4: c = -60;  5: c = 20;   6: c = -4;
                   default: c = 0;
               endcase
            default: case (k)
                   0: c = -2;   1: c = 16;   2: c = -60;  3: c = 940;
                   4: c = 170;  5: c = -50;  6: c = 10;
                   default: c = 0;
               endcase
        endcase
        return c;
    endfunction

endpackage

// File: rtl/qup_signflip.sv
module qup_signflip #(
    parameter int W = 12
) (
    input  logic signed [W-1:0] a,
    input  logic                neg,
    output logic signed [W-1:0] y
);
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        if (!neg)            y = a;
        else if (a == MINV)  y = MAXV;
        else                 y = -a;
    end
endmodule

// File: rtl/qup_branch.sv
module qup_branch #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12,
    parameter int FRAC  = 10,
    parameter int DEPTH = 8,
    parameter int BR    = 0
) (
    input  logic [DEPTH-1:0][IN_W-1:0] line,
    input  logic                       neg,
    output logic signed [OUT_W-1:0]    y
);
    import qup_pkg::*;

    localparam int NTAP  = branch_taps(BR);
    localparam int ACC_W = 32;
    localparam int SHIFT = FRAC + IN_W - OUT_W;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (SHIFT - 1);
    localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (OUT_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(1) <<< (OUT_W - 1));

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] scaled;
    logic signed [OUT_W-1:0] clipped;

    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAP; k++) begin
            acc = acc + ACC_W'($signed(line[k])) * ACC_W'(tap_coef(BR, k));
        end
        scaled = (acc + HALF) >>> SHIFT;
        if (scaled > MAXV)      clipped = MAXV[OUT_W-1:0];
        else if (scaled < MINV) clipped = MINV[OUT_W-1:0];
        else                    clipped = scaled[OUT_W-1:0];
    end

    qup_signflip #(.W(OUT_W)) u_flip (
        .a   (clipped),
        .neg (neg),
        .y   (y)
    );
endmodule

// File: rtl/qup_interp.sv
module qup_interp #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12,
    parameter int FRAC  = 10,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  x_in,
    input  logic [IN_W-1:0]  y_in,
    input  logic [1:0]       mode,
    input  logic             dir_neg,
    output logic [OUT_W-1:0] dac_out
);
    import qup_pkg::*;

    localparam int NBR = 4;
    localparam int PW  = $clog2(NBR);

    typedef struct packed {
        logic [PW-1:0]                  phase;
        qmode_e                         mode;
        logic [DEPTH-1:0][IN_W-1:0]     xl;
        logic [DEPTH-1:0][IN_W-1:0]     al;
        logic [NBR-1:0][OUT_W-1:0]      br;
        logic [OUT_W-1:0]               dac;
    } state_t;

    state_t s_d, s_q;

    logic                        accept;
    qmode_e                      mode_in;
    logic [IN_W-1:0]             push_x, push_a;
    logic [DEPTH-1:0][IN_W-1:0]  xl_nx, al_nx;
    logic [NBR-1:0]              neg_v;
    logic [NBR-1:0][OUT_W-1:0]   br_w;

    // shifted delay lines and branch signs for the sample taken at phase 0
    always_comb begin
        accept  = (s_q.phase == '0);
        mode_in = qmode_e'(mode);
        push_x  = in_valid ? x_in : '0;
        push_a  = !in_valid ? '0 : ((mode_in == MODE_BAND) ? y_in : x_in);
        xl_nx   = {s_q.xl[DEPTH-2:0], push_x};
        al_nx   = {s_q.al[DEPTH-2:0], push_a};
        case (mode_in)
            MODE_BAND: neg_v = dir_neg ? 4'b0110 : 4'b1100;
            MODE_HIGH: neg_v = 4'b1010;
            default:   neg_v = 4'b0000;
        endcase
    end

    for (genvar b = 0; b < NBR; b++) begin : g_br
        if (b % 2 == 0) begin : g_x
            qup_branch #(.IN_W(IN_W), .OUT_W(OUT_W), .FRAC(FRAC), .DEPTH(DEPTH), .BR(b)) u_br (
                .line (xl_nx),
                .neg  (neg_v[b]),
                .y    (br_w[b])
            );
        end else begin : g_a
            qup_branch #(.IN_W(IN_W), .OUT_W(OUT_W), .FRAC(FRAC), .DEPTH(DEPTH), .BR(b)) u_br (
                .line (al_nx),
                .neg  (neg_v[b]),
                .y    (br_w[b])
            );
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.phase = s_q.phase + PW'(1);
        s_d.dac   = s_q.br[s_q.phase - PW'(1)];
        if (accept) begin
            s_d.xl   = xl_nx;
            s_d.al   = al_nx;
            s_d.br   = br_w;
            s_d.mode = mode_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: '0, mode: MODE_LOW, xl: '0, al: '0, br: '0, dac: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign dac_out = s_q.dac;

    // plain views of state for the bound checker
    logic [PW-1:0]              dbg_phase;
    logic [1:0]                 dbg_mode;
    logic [DEPTH-1:0][IN_W-1:0] dbg_xl, dbg_al;
    logic [NBR-1:0][OUT_W-1:0]  dbg_br;

    assign dbg_phase = s_q.phase;
    assign dbg_mode  = s_q.mode;
    assign dbg_xl    = s_q.xl;
    assign dbg_al    = s_q.al;
    assign dbg_br    = s_q.br;
endmodule

// File: rtl/qup_interp_chk.sv
module qup_interp_chk #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12,
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [1:0]                 phase_q,
    input logic [1:0]                 mode_q,
    input logic [DEPTH-1:0][IN_W-1:0] xl_q,
    input logic [DEPTH-1:0][IN_W-1:0] al_q,
    input logic [3:0][OUT_W-1:0]      br_q,
    input logic [OUT_W-1:0]           dac_q
);
    // R1: phase counter steps by one modulo four
    a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase_q == $past(phase_q) + 2'd1);

    // R2: output register carries the branch result in slot order
    a_r2_mux_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != 2'd1) |-> dac_q == br_q[phase_q - 2'd2]);

    // R4: outside bandpass both delay lines receive the X sample
    a_r4_route_x: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 2'b01) |-> al_q[0] == xl_q[0]);

    // R10: delay lines move only at phase-0 edges
    a_r10_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != 2'd0) |=> $stable(xl_q) && $stable(al_q));

    // R11: branch results change only at phase-0 edges
    a_r11_branch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != 2'd0) |=> $stable(br_q));
endmodule

bind qup_interp qup_interp_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_q (dbg_phase),
    .mode_q  (dbg_mode),
    .xl_q    (dbg_xl),
    .al_q    (dbg_al),
    .br_q    (dbg_br),
    .dac_q   (dac_out)
);

// File: tb/sim_qup_interp.sv
`timescale 1ns/1ps
module sim_qup_interp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] x_in = '0;
    logic [15:0] y_in = '0;
    logic [1:0]  mode = 2'b00;
    logic        dir_neg = 1'b0;
    logic [11:0] dac_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int prev3, cur0, cur1, cur2;
    int res [4];

    always #2.5 clk = ~clk;

    qup_interp u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .y_in(y_in),
        .mode(mode), .dir_neg(dir_neg), .dac_out(dac_out)
    );

    function automatic int scale12(input int v);
        int t;
        t = (v + 8) >>> 4;
        if (t > 2047) t = 2047;
        if (t < -2048) t = -2048;
        return t;
    endfunction

    function automatic int flip(input int v);
        return (v == -2048) ? 2047 : -v;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d exp %0d", req, got, exp);
        end
    endtask

    // called at the negedge of a phase-0 cycle, returns at the next one
    task automatic run_period(input int x, input int y, input logic [1:0] m,
                              input logic d, input logic v, input bit gl, input bit late);
        in_valid = v; x_in = 16'(x); y_in = 16'(y); mode = m; dir_neg = d;
        @(posedge clk); #1 prev3 = $signed(dac_out);
        @(negedge clk);
        in_valid = late;
        if (late) begin x_in = 16'(-20000); y_in = 16'(20000); end
        if (gl) begin mode = (m == 2'b10) ? 2'b00 : 2'b10; dir_neg = ~d; end
        @(posedge clk); #1 cur0 = $signed(dac_out);
        @(negedge clk);
        @(posedge clk); #1 cur1 = $signed(dac_out);
        @(negedge clk);
        in_valid = 1'b0; mode = m; dir_neg = d;
        @(posedge clk); #1 cur2 = $signed(dac_out);
        @(negedge clk);
    endtask

    task automatic settle(input int x, input int y, input logic [1:0] m,
                          input logic d, input logic v);
        for (int i = 0; i < 9; i++) run_period(x, y, m, d, v, 0, 0);
    endtask

    task automatic grab(input int x, input int y, input logic [1:0] m,
                        input logic d, input bit gl, input bit late);
        run_period(x, y, m, d, 1'b1, gl, late);
        res[0] = cur0; res[1] = cur1; res[2] = cur2;
        run_period(x, y, m, d, 1'b1, 0, 0);
        res[3] = prev3;
    endtask

    task automatic expect4(input string req, input int e0, input int e1,
                           input int e2, input int e3);
        chk(req, res[0], e0); chk(req, res[1], e1);
        chk(req, res[2], e2); chk(req, res[3], e3);
    endtask

    task automatic t_reset;
        chk("R1 reset output", $signed(dac_out), 0);
    endtask

    task automatic t_lowpass;
        int a;
        a = scale12(1600);
        settle(1600, -900, 2'b00, 1'b0, 1'b1);
        grab(1600, -900, 2'b00, 1'b0, 0, 0);
        expect4("R4 lowpass / R3 unity gain", a, a, a, a);
        settle(1600, 7000, 2'b11, 1'b1, 1'b1);
        grab(1600, 7000, 2'b11, 1'b1, 0, 0);
        expect4("R4 lowpass code 11", a, a, a, a);
    endtask

    task automatic t_band_pos;
        int a, b;
        a = scale12(3200); b = scale12(-1600);
        settle(3200, -1600, 2'b01, 1'b0, 1'b1);
        grab(3200, -1600, 2'b01, 1'b0, 0, 0);
        expect4("R5 bandpass +fs/4 / R2 order", a, b, flip(a), flip(b));
    endtask

    task automatic t_band_neg;
        int a, b;
        a = scale12(3200); b = scale12(-1600);
        settle(3200, -1600, 2'b01, 1'b1, 1'b1);
        grab(3200, -1600, 2'b01, 1'b1, 0, 0);
        expect4("R6 bandpass -fs/4", a, flip(b), flip(a), b);
    endtask

    task automatic t_highpass;
        int a;
        a = scale12(4800);
        settle(4800, 9999, 2'b10, 1'b1, 1'b1);
        grab(4800, 9999, 2'b10, 1'b1, 0, 0);
        expect4("R7 highpass", a, flip(a), a, flip(a));
    endtask

    task automatic t_round;
        int vals [4] = '{8, 7, -8, -9};
        int exps [4] = '{1, 0, 0, -1};
        for (int i = 0; i < 4; i++) begin
            settle(vals[i], 0, 2'b00, 1'b0, 1'b1);
            grab(vals[i], 0, 2'b00, 1'b0, 0, 0);
            chk("R8 rounding", res[0], exps[i]);
            chk("R8 rounding", scale12(vals[i]), exps[i]);
        end
    endtask

    task automatic t_saturate;
        settle(-32768, 0, 2'b10, 1'b0, 1'b1);
        grab(-32768, 0, 2'b10, 1'b0, 0, 0);
        expect4("R9 saturating negate", -2048, 2047, -2048, 2047);
        settle(32767, 0, 2'b00, 1'b0, 1'b1);
        grab(32767, 0, 2'b00, 1'b0, 0, 0);
        expect4("R8 positive clip", 2047, 2047, 2047, 2047);
    endtask

    task automatic t_mode_boundary;
        int a;
        a = scale12(1600);
        settle(1600, 0, 2'b00, 1'b0, 1'b1);
        grab(1600, 0, 2'b00, 1'b0, 1, 0);
        expect4("R11 mid-period mode change ignored", a, a, a, a);
        grab(1600, 0, 2'b10, 1'b0, 0, 0);
        expect4("R11 mode applied at phase 0", a, flip(a), a, flip(a));
    endtask

    task automatic t_strobe;
        int a;
        a = scale12(1600);
        settle(1600, 0, 2'b00, 1'b0, 1'b1);
        grab(1600, 0, 2'b00, 1'b0, 0, 1);
        expect4("R10 late strobe ignored", a, a, a, a);
        settle(1600, 0, 2'b00, 1'b0, 1'b0);
        grab(0, 0, 2'b00, 1'b0, 0, 0);
        expect4("R10 missing strobe pushes zero", 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_lowpass();
        t_band_pos();
        t_band_neg();
        t_highpass();
        t_round();
        t_saturate();
        t_mode_boundary();
        t_strobe();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule